// File: doc/BRIEF.md
# Segmented Base-Register Address Generator

This block turns an address value from a load, a store or an instruction fetch into a 64-bit linear address. It holds sixteen 64-bit segment base registers. A 4-bit selector field, taken from the top of the address value at the configured address width, picks one of these registers. The base is scaled to 16-byte units and then added to the offset bits that lie below the selector. Instruction fetches always use the code base register, which is the highest index. The data base register is index 0, so an address value with its upper bits clear lands in the data segment.

The low nibble of each base register is not part of the segment start. Three of its bits grant read, write and execute rights. An access whose type is not granted produces a one-cycle fault instead of an address. The register file can be written with a move-to-base operation and read back with a move-from-base operation. The result pipeline is a single register stage, so a response appears in the cycle after its request.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` and `fault` are 0. All base registers hold 0, except index 15 (code base), which holds `CODE_BASE_RST` (default 64'h1005: segment start 0x1000, read and execute granted).
- R2: The address-width code selects the field layout. 2'b01 means 24-bit: the selector is bits 23:20 and the offset is bits 19:0. 2'b10 means 32-bit: the selector is bits 31:28 and the offset is bits 27:0. Codes 2'b00 and 2'b11 behave as 32-bit. Bits above the configured width have no effect.
- R3: For a granted request, `out_addr` in the next cycle equals (selected base with bits 3:0 cleared) plus the zero-extended offset, taken modulo 2^64. `out_valid` is 1 in that same cycle.
- R4: The value that is split into selector and offset is `req_addr` plus the sign-extended 11-bit `req_disp`, taken modulo 2^64.
- R5: `req_kind` encodes the access: 2'b00 is load, 2'b01 is store, 2'b10 is fetch, 2'b11 is reserved. A fetch always uses base 15, whatever its selector bits hold. Loads and stores use the selected base.
- R6: Base bit 0 grants read, bit 1 grants write and bit 2 grants execute. A load needs read, a store needs write, a fetch needs execute, and the reserved kind is never granted. A request that is not granted gives `fault`=1 and `out_valid`=0 in the next cycle, and `out_addr` keeps its previous value.
- R7: When no request is present, `out_valid` and `fault` are both 0 in the next cycle.
- R8: A move-to-base write (`mtb_en`) takes effect at the clock edge. A request in the same cycle as the write uses the old value, and a request in the following cycle uses the new value.
- R9: `mfb_data` combinationally shows base register `mfb_idx`. In the cycle of a write to that index it still shows the old value.
- R10: An address value below 2^(width-4), at the configured width, selects base 0 (data base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Address-width code from control register zero |
| req_valid | input | 1 | Address request present |
| req_kind | input | 2 | Access kind (load, store, fetch, reserved) |
| req_addr | input | 64 | Address value carrying the selector field |
| req_disp | input | 11 | Signed displacement |
| mtb_en | input | 1 | Move-to-base write enable |
| mtb_idx | input | 4 | Base register written |
| mtb_data | input | 64 | Value written (bits 3:0 are rights) |
| mfb_idx | input | 4 | Base register read back |
| mfb_data | output | 64 | Read-back value |
| out_valid | output | 1 | Linear address valid |
| out_addr | output | 64 | Linear address |
| fault | output | 1 | Access rights violation |

## Verification
The main path is swept over every combination of width code (all four, including the two that fall back to 32-bit), all sixteen selector values and all four access kinds. In this sweep, junk sits above the configured width, so a wrong field position or a missing mask shows up as a wrong base or offset. The base values give every rights combination and include one near the top of the 64-bit range, so the sweep also tells the fault decision apart from the wrap of the final add. Separate patterns cover three cases: a positive and a negative displacement, including one that borrows into the selector field; a fetch whose selector bits point somewhere other than the code base; and a request that coincides with a write to the base it uses.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   localparam logic [1:0] WCODE_24 = 2'b01;
   localparam logic [1:0] WCODE_32 = 2'b10;

   localparam int RIGHT_RD = 0;
   localparam int RIGHT_WR = 1;
   localparam int RIGHT_EX = 2;
   localparam int RIGHTS_W = 3;

   // number of supported address widths and their sizes
   localparam int N_WMODES = 2;

   function automatic int wmode_bits(input int m);
      return (m == 0) ? 24 : 32;
   endfunction

   function automatic logic kind_granted(input logic [RIGHTS_W-1:0] r,
                                         input acc_kind_e k);
      logic ok;
      case (k)
         ACC_LOAD:  ok = r[RIGHT_RD];
         ACC_STORE: ok = r[RIGHT_WR];
         ACC_FETCH: ok = r[RIGHT_EX];
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/sag_base_file.sv
module sag_base_file #(
   parameter int          NUM      = 16,
   parameter int          DW       = 64,
   parameter int          CODE_IDX = NUM - 1,
   parameter logic [63:0] CODE_RST = 64'h1005,
   localparam int         IW       = $clog2(NUM)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] ra_idx,
   output logic [DW-1:0] ra_data,
   input  logic [IW-1:0] rb_idx,
   output logic [DW-1:0] rb_data
);

   logic [DW-1:0] regs [NUM];

   generate
      if (CODE_IDX < 0 || CODE_IDX >= NUM) begin : g_bad_code
         $error("sag_base_file: CODE_IDX out of range");
      end
      for (genvar i = 0; i < NUM; i++) begin : g_reg
         localparam logic [DW-1:0] RST_V = (i == CODE_IDX) ? CODE_RST[DW-1:0] : '0;
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RST_V;
            else if (wr_en && (wr_idx == IW'(i)))
               q <= wr_data;
         end
         assign regs[i] = q;
      end
   endgenerate

   // reads see the register state before any write in this cycle
   assign ra_data = regs[ra_idx];
   assign rb_data = regs[rb_idx];

endmodule

// File: rtl/sag_sel_decode.sv
module sag_sel_decode #(
   parameter int ADDR_W = 64,
   parameter int SEL_W  = 4
) (
   input  logic [ADDR_W-1:0] eff,
   input  logic [1:0]        width_code,
   output logic [SEL_W-1:0]  sel,
   output logic [ADDR_W-1:0] offset
);
   import sag_pkg::*;

   logic [SEL_W-1:0]  sel_m [N_WMODES];
   logic [ADDR_W-1:0] off_m [N_WMODES];

   generate
      for (genvar m = 0; m < N_WMODES; m++) begin : g_mode
         localparam int W  = wmode_bits(m);
         localparam int OW = W - SEL_W;
         if (W > ADDR_W || OW < 1) begin : g_bad_w
            $error("sag_sel_decode: width mode does not fit ADDR_W/SEL_W");
         end
         // selector is the top SEL_W bits at this width, offset is below it
         assign sel_m[m] = eff[W-1 -: SEL_W];
         assign off_m[m] = {{(ADDR_W-OW){1'b0}}, eff[OW-1:0]};
      end
   endgenerate

   // only the 24-bit code picks the narrow layout; every other code is 32-bit
   logic narrow;
   assign narrow = (width_code == WCODE_24);

   always_comb begin
      if (narrow) begin
         sel    = sel_m[0];
         offset = off_m[0];
      end else begin
         sel    = sel_m[1];
         offset = off_m[1];
      end
   end

endmodule

// File: rtl/sag_rights.sv
module sag_rights #(
   parameter bit ENFORCE = 1'b1
) (
   input  logic [sag_pkg::RIGHTS_W-1:0] rights,
   input  sag_pkg::acc_kind_e           kind,
   output logic                         allow
);
   import sag_pkg::*;

   generate
      if (ENFORCE) begin : g_check
         assign allow = kind_granted(rights, kind);
      end else begin : g_open
         // rights ignored; only the reserved kind is refused
         assign allow = (kind != ACC_RSVD);
      end
   endgenerate

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int          ADDR_W        = 64,
   parameter int          SEL_W         = 4,
   parameter int          SEG_SHIFT     = 4,
   parameter int          DISP_W        = 11,
   parameter bit          ENFORCE       = 1'b1,
   parameter logic [63:0] CODE_BASE_RST = 64'h1005,
   localparam int         NUM_BASE      = 1 << SEL_W,
   localparam int         CODE_IDX      = NUM_BASE - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_width,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DISP_W-1:0] req_disp,
   input  logic              mtb_en,
   input  logic [SEL_W-1:0]  mtb_idx,
   input  logic [ADDR_W-1:0] mtb_data,
   input  logic [SEL_W-1:0]  mfb_idx,
   output logic [ADDR_W-1:0] mfb_data,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              fault
);
   import sag_pkg::*;

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_aw
         $error("seg_addr_gen: ADDR_W must be 32..64");
      end
      if (SEG_SHIFT < RIGHTS_W || SEG_SHIFT >= ADDR_W) begin : g_bad_sh
         $error("seg_addr_gen: SEG_SHIFT must hold the rights bits");
      end
      if (DISP_W < 2 || DISP_W >= ADDR_W) begin : g_bad_dw
         $error("seg_addr_gen: DISP_W out of range");
      end
      if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
         $error("seg_addr_gen: SEL_W out of range");
      end
   endgenerate

   // effective value: address plus sign-extended displacement
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] eff;
   assign disp_ext = {{(ADDR_W-DISP_W){req_disp[DISP_W-1]}}, req_disp};
   assign eff      = req_addr + disp_ext;

   acc_kind_e kind;
   assign kind = acc_kind_e'(req_kind);

   logic [SEL_W-1:0]  sel_fld;
   logic [ADDR_W-1:0] offset;

   sag_sel_decode #(
      .ADDR_W (ADDR_W),
      .SEL_W  (SEL_W)
   ) u_dec (
      .eff        (eff),
      .width_code (cfg_width),
      .sel        (sel_fld),
      .offset     (offset)
   );

   // instruction fetch is pinned to the code segment
   logic [SEL_W-1:0] sel_use;
   assign sel_use = (kind == ACC_FETCH) ? SEL_W'(CODE_IDX) : sel_fld;

   logic [ADDR_W-1:0] base_q;

   sag_base_file #(
      .NUM      (NUM_BASE),
      .DW       (ADDR_W),
      .CODE_IDX (CODE_IDX),
      .CODE_RST (CODE_BASE_RST)
   ) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mtb_en),
      .wr_idx  (mtb_idx),
      .wr_data (mtb_data),
      .ra_idx  (sel_use),
      .ra_data (base_q),
      .rb_idx  (mfb_idx),
      .rb_data (mfb_data)
   );

   logic allow;

   sag_rights #(
      .ENFORCE (ENFORCE)
   ) u_rights (
      .rights (base_q[RIGHTS_W-1:0]),
      .kind   (kind),
      .allow  (allow)
   );

   // segment start: base in 16-byte units, rights nibble dropped
   logic [ADDR_W-1:0] seg_start;
   logic [ADDR_W-1:0] lin;
   assign seg_start = {base_q[ADDR_W-1:SEG_SHIFT], {SEG_SHIFT{1'b0}}};
   assign lin       = seg_start + offset;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         fault     <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= req_valid && allow;
         fault     <= req_valid && !allow;
         if (req_valid && allow)
            out_addr <= lin;
      end
   end

endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
   parameter int          ADDR_W        = 64,
   parameter int          SEL_W         = 4,
   parameter logic [63:0] CODE_BASE_RST = 64'h1005
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              mtb_en,
   input logic [SEL_W-1:0]  mtb_idx,
   input logic [ADDR_W-1:0] mtb_data,
   input logic [SEL_W-1:0]  mfb_idx,
   input logic [ADDR_W-1:0] mfb_data,
   input logic              out_valid,
   input logic              fault
);
   localparam logic [SEL_W-1:0] CODE_I = {SEL_W{1'b1}};

   // R6
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault && out_valid));

   // R7
   resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || fault) |-> $past(req_valid));

   // R3
   req_gets_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_valid ^ fault));

   // R8
   mtb_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mtb_en) && (mfb_idx == $past(mtb_idx)))
      |-> (mfb_data == $past(mtb_data)));

   // R1
   code_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && (mfb_idx == CODE_I))
      |-> (mfb_data == CODE_BASE_RST[ADDR_W-1:0]));

   // R9
   mfb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(mtb_en) && $stable(mfb_idx)) |-> $stable(mfb_data));

endmodule

bind seg_addr_gen sag_chk #(
   .ADDR_W        (ADDR_W),
   .SEL_W         (SEL_W),
   .CODE_BASE_RST (CODE_BASE_RST)
) i_sag_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .mtb_en    (mtb_en),
   .mtb_idx   (mtb_idx),
   .mtb_data  (mtb_data),
   .mfb_idx   (mfb_idx),
   .mfb_data  (mfb_data),
   .out_valid (out_valid),
   .fault     (fault)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

   localparam logic [63:0] CODE_RST = 64'h1005;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_width = 2'b10;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [63:0] req_addr = '0;
   logic [10:0] req_disp = '0;
   logic        mtb_en = 1'b0;
   logic [3:0]  mtb_idx = '0;
   logic [63:0] mtb_data = '0;
   logic [3:0]  mfb_idx = '0;
   logic [63:0] mfb_data;
   logic        out_valid;
   logic [63:0] out_addr;
   logic        fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [63:0] model [16];

   always #2.5 clk = ~clk;

   seg_addr_gen i_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_disp(req_disp), .mtb_en(mtb_en), .mtb_idx(mtb_idx),
      .mtb_data(mtb_data), .mfb_idx(mfb_idx), .mfb_data(mfb_data),
      .out_valid(out_valid), .out_addr(out_addr), .fault(fault)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reference arithmetic built from the requirements
   function automatic void predict(input logic [1:0] kind, input logic [63:0] addr,
                                   input logic [10:0] disp, input logic [1:0] wc,
                                   output logic ok, output logic [63:0] lin);
      logic [63:0] eff;
      int          w;
      int          s;
      logic [2:0]  r;
      eff = addr + {{53{disp[10]}}, disp};
      w   = (wc == 2'b01) ? 24 : 32;
      s   = int'((eff >> (w - 4)) & 64'hF);
      if (kind == 2'b10) s = 15;
      r   = model[s][2:0];
      case (kind)
         2'b00:   ok = r[0];
         2'b01:   ok = r[1];
         2'b10:   ok = r[2];
         default: ok = 1'b0;
      endcase
      lin = (model[s] & ~64'hF) + (eff & ((64'h1 << (w - 4)) - 64'h1));
   endfunction

   // called just after a falling edge; returns just after the next one
   task automatic do_req(input string req, input logic [1:0] kind, input logic [63:0] addr,
                         input logic [10:0] disp, input logic [1:0] wc);
      logic        ok;
      logic [63:0] lin;
      logic [63:0] prev;
      prev = out_addr;
      predict(kind, addr, disp, wc, ok, lin);
      req_valid = 1'b1; req_kind = kind; req_addr = addr; req_disp = disp; cfg_width = wc;
      @(negedge clk);
      if (ok) begin
         chk(req, {62'd0, fault, out_valid}, 64'd1);
         chk(req, out_addr, lin);
      end else begin
         chk(req, {62'd0, fault, out_valid}, 64'd2);
         chk(req, out_addr, prev);
      end
   endtask

   task automatic wr_base(input int i, input logic [63:0] v);
      req_valid = 1'b0;
      mtb_en = 1'b1; mtb_idx = 4'(i); mtb_data = v;
      @(negedge clk);
      mtb_en = 1'b0;
      model[i] = v;
   endtask

   initial begin : watchdog
      #(5.0 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] oldv;
      logic [63:0] newv;
      logic        ok;
      logic [63:0] lin_old;
      logic [63:0] lin_new;
      for (int i = 0; i < 16; i++) model[i] = (i == 15) ? CODE_RST : 64'd0;

      repeat (3) @(negedge clk);
      chk("R1 outputs in reset", {62'd0, fault, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", {62'd0, fault, out_valid}, 64'd0);
      for (int i = 0; i < 16; i++) begin
         mfb_idx = 4'(i);
         #1;
         chk("R1 R9 reset base value", mfb_data, model[i]);
      end
      @(negedge clk);

      // R5 fetch from reset code base, selector bits point elsewhere
      do_req("R5 R1 fetch from reset code base", 2'b10, 64'h3000_0120, 11'd0, 2'b10);
      // R6 load from base 3 after reset has no rights
      do_req("R6 load with no rights", 2'b00, 64'h3000_0000, 11'd0, 2'b10);

      // load every base with distinct starts and every rights pattern
      for (int i = 0; i < 16; i++) begin
         logic [63:0] v;
         v = (64'(i) * 64'h0000_0123_4567_0000) + 64'(i * 48);
         if (i == 14) v = 64'hFFFF_FFFF_FFFF_FFF0;
         v = (v & ~64'hF) | 64'((i + 7) % 8);
         wr_base(i, v);
      end
      for (int i = 0; i < 16; i++) begin
         mfb_idx = 4'(i);
         #1;
         chk("R8 R9 readback after move-to-base", mfb_data, model[i]);
      end
      @(negedge clk);

      // R2 R3 R5 R6 R10 sweep: width code x selector x kind, junk above width
      for (int wi = 0; wi < 4; wi++) begin
         for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 4; k++) begin
               logic [63:0] a;
               int w;
               w = (wi == 1) ? 24 : 32;
               a = 64'hA5A5_0000_0000_0000
                 | (64'(s) << (w - 4))
                 | (64'(s * 4099 + k * 16 + 32) & ((64'h1 << (w - 4)) - 64'h1));
               if (w == 24) a = a | 64'hC3_00_0000;
               do_req("R2 R3 R5 R6 R10 sweep", 2'(k), a, 11'd0, 2'(wi));
            end
         end
      end

      // R7 idle after request
      req_valid = 1'b0;
      @(negedge clk);
      chk("R7 no request", {62'd0, fault, out_valid}, 64'd0);

      // R4 displacements on data base 0 (rights 7)
      do_req("R4 negative disp", 2'b00, 64'h0000_0100, 11'h7FD, 2'b10);
      do_req("R4 max positive disp", 2'b01, 64'h0000_1000, 11'h3FF, 2'b01);
      do_req("R4 min negative disp", 2'b00, 64'h0000_1000, 11'h400, 2'b10);
      // borrow into the selector field: result selects base 15
      do_req("R4 disp borrow into selector", 2'b01, 64'h0000_0002, 11'h7FD, 2'b10);
      // R10 small address in 24-bit mode lands on base 0
      do_req("R10 zero high bits", 2'b00, 64'h0000_0000_0003_4560, 11'd0, 2'b01);

      // R8 R9 write and request to the same base in one cycle
      oldv = model[2];
      newv = 64'h0000_0000_0777_0007;
      predict(2'b00, 64'h2000_0040, 11'd0, 2'b10, ok, lin_old);
      mtb_en = 1'b1; mtb_idx = 4'd2; mtb_data = newv; mfb_idx = 4'd2;
      req_valid = 1'b1; req_kind = 2'b00; req_addr = 64'h2000_0040; req_disp = '0; cfg_width = 2'b10;
      #1;
      chk("R9 same-cycle readback old", mfb_data, oldv);
      @(negedge clk);
      mtb_en = 1'b0;
      model[2] = newv;
      chk("R8 same-cycle request uses old base", {63'd0, out_valid}, {63'd0, ok});
      chk("R8 same-cycle request uses old base", out_addr, lin_old);
      chk("R9 readback new value", mfb_data, newv);
      predict(2'b00, 64'h2000_0040, 11'd0, 2'b10, ok, lin_new);
      @(negedge clk);
      chk("R8 next-cycle request uses new base", {62'd0, fault, out_valid}, 64'd1);
      chk("R8 next-cycle request uses new base", out_addr, lin_new);
      req_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule